// File: doc/BRIEF.md
# Configurable-Sign Registered Multiplier

This block multiplies two 16-bit operands and returns a 32-bit product. Each operand is captured into its own register. The capture is gated by an active-low load enable. Each operand also carries a flag that declares it unsigned or two's complement, so signed, unsigned and mixed products are all supported. A rounding request is registered alongside the operands. When it is set, half an output LSB is added so that keeping only the upper half gives a correctly rounded 16-bit result.

The rounded product passes through a format stage. That stage either keeps the full 32-bit layout or shifts the product left by one into a 31-bit layout. In the shifted layout the sign bit is duplicated into the top of the lower half. The two formatted halves are then held in result registers. Those registers can be made transparent for a combinational path.

A selector chooses which half drives the main output. The lower half also has a separate output of its own. Each output has an enable, and a matching valid flag shows when that output is driven.

Top module: `cfgsign_mul`

## Requirements
- R1: The A operand and its sign flag are captured on a rising clock edge when `a_load_n` is 0. When `a_load_n` is 1 they keep their value.
- R2: The B operand and its sign flag are captured on a rising clock edge when `b_load_n` is 0. When `b_load_n` is 1 they keep their value.
- R3: A sign flag of 1 makes its operand two's complement, and 0 makes it unsigned. Each flag applies only to its own operand. The product is the exact product of the two 17-bit extended values, truncated to 32 bits.
- R4: The rounding request is captured on a rising clock edge when at least one of `a_load_n` or `b_load_n` is 0. When both are 1 it keeps its value.
- R5: A captured rounding request of 1 adds 2^15 to the 32-bit product, modulo 2^32, before formatting.
- R6: With `fmt_full` = 0 the upper half is product bits 30..15. The lower half is product bit 31 in bit 15, followed by product bits 14..0.
- R7: With `fmt_full` = 1 the upper half is product bits 31..16 and the lower half is bits 15..0.
- R8: The result registers load the formatted halves on a rising clock edge when `res_load_n` is 0. When `res_load_n` is 1 they hold.
- R9: When `pass_thru` is 1 and `res_load_n` is 0, the outputs show the formatted halves of the current operand registers without waiting for a clock edge.
- R10: With `hi_sel` = 0, `main_out` shows the upper half. With `hi_sel` = 1 it shows the lower half.
- R11: `low_out` always shows the lower half. When `main_oe` or `low_oe` is 0, its output is 0 and its valid flag is 0. When the enable is 1, the valid flag is 1.
- R12: A synchronous active-high `rst` clears the operand registers, sign flags, rounding request and result registers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 16 | A operand |
| a_tc | input | 1 | A is two's complement when 1 |
| a_load_n | input | 1 | Capture A when 0 |
| b_in | input | 16 | B operand |
| b_tc | input | 1 | B is two's complement when 1 |
| b_load_n | input | 1 | Capture B when 0 |
| rnd_in | input | 1 | Rounding request |
| fmt_full | input | 1 | 1 selects the full 32-bit layout, 0 the shifted 31-bit layout |
| res_load_n | input | 1 | Load the result registers when 0 |
| pass_thru | input | 1 | Make the result registers transparent when 1 (with `res_load_n` = 0) |
| hi_sel | input | 1 | 0 puts the upper half on `main_out`, 1 puts the lower half |
| main_oe | input | 1 | Enable for `main_out` |
| low_oe | input | 1 | Enable for `low_out` |
| main_out | output | 16 | Selected result half |
| main_vld | output | 1 | `main_out` is driven |
| low_out | output | 16 | Lower result half |
| low_vld | output | 1 | `low_out` is driven |

## Verification
The bench builds the block at its default operand width of 16 bits. At that width the directed corners can hit the exact boundary bits. These include the duplicated sign bit at position 15 of the lower half, a rounding carry out of bit 15 into the upper half, and the square of the most negative value in the shifted layout. Seeded random operands, flags and controls then cover signed, unsigned and mixed products in both layouts, with and without feed-through, enables or holds.

// File: rtl/cfgmul_pkg.sv
package cfgmul_pkg;
    typedef enum logic {
        FMT_SHIFTED = 1'b0,
        FMT_FULL    = 1'b1
    } fmt_e;

    typedef enum logic {
        SEL_UPPER = 1'b0,
        SEL_LOWER = 1'b1
    } hsel_e;
endpackage

// File: rtl/opnd_reg.sv
module opnd_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_n,
    input  logic [W-1:0] d,
    input  logic         tc_d,
    output logic [W-1:0] q,
    output logic         tc_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q    <= '0;
            tc_q <= 1'b0;
        end else if (!load_n) begin
            q    <= d;
            tc_q <= tc_d;
        end
    end
endmodule

// File: rtl/round_mult.sv
module round_mult #(
    parameter int W = 16
) (
    input  logic [W-1:0]   a,
    input  logic           a_tc,
    input  logic [W-1:0]   b,
    input  logic           b_tc,
    input  logic           rnd,
    output logic [2*W-1:0] prod
);
    localparam int PW = 2 * W;
    localparam int XW = W + 1;

    logic signed [XW-1:0]   ext_a;
    logic signed [XW-1:0]   ext_b;
    logic signed [2*XW-1:0] wide;
    logic        [PW-1:0]   rnd_add;

    always_comb begin
        ext_a   = $signed({a_tc & a[W-1], a});
        ext_b   = $signed({b_tc & b[W-1], b});
        wide    = ext_a * ext_b;
        rnd_add = PW'(rnd) << (W - 1);
        prod    = wide[PW-1:0] + rnd_add;
    end
endmodule

// File: rtl/fmt_adj.sv
module fmt_adj
    import cfgmul_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [2*W-1:0] prod,
    input  logic           full,
    output logic [W-1:0]   hi,
    output logic [W-1:0]   lo
);
    localparam int PW = 2 * W;

    fmt_e mode;

    always_comb begin
        mode = fmt_e'(full);
        unique case (mode)
            FMT_FULL: begin
                hi = prod[PW-1 -: W];
                lo = prod[W-1:0];
            end
            FMT_SHIFTED: begin
                hi = prod[PW-2 -: W];
                lo = {prod[PW-1], prod[W-2:0]};
            end
            default: begin
                hi = '0;
                lo = '0;
            end
        endcase
    end
endmodule

// File: rtl/res_out.sv
module res_out
    import cfgmul_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_n,
    input  logic         pass,
    input  logic [W-1:0] hi_d,
    input  logic [W-1:0] lo_d,
    input  logic         sel,
    input  logic         main_oe,
    input  logic         low_oe,
    output logic [W-1:0] hi_q,
    output logic [W-1:0] lo_q,
    output logic [W-1:0] main_out,
    output logic         main_vld,
    output logic [W-1:0] low_out,
    output logic         low_vld
);
    logic [W-1:0] vis_hi;
    logic [W-1:0] vis_lo;
    logic [W-1:0] picked;
    hsel_e        which;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (!load_n) begin
            hi_q <= hi_d;
            lo_q <= lo_d;
        end
    end

    always_comb begin
        if (pass && !load_n) begin
            vis_hi = hi_d;
            vis_lo = lo_d;
        end else begin
            vis_hi = hi_q;
            vis_lo = lo_q;
        end
        which = hsel_e'(sel);
        unique case (which)
            SEL_UPPER: picked = vis_hi;
            SEL_LOWER: picked = vis_lo;
            default:   picked = '0;
        endcase
        main_out = main_oe ? picked : '0;
        main_vld = main_oe;
        low_out  = low_oe ? vis_lo : '0;
        low_vld  = low_oe;
    end
endmodule

// File: rtl/cfgsign_mul.sv
module cfgsign_mul #(
    parameter int OP_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] a_in,
    input  logic            a_tc,
    input  logic            a_load_n,
    input  logic [OP_W-1:0] b_in,
    input  logic            b_tc,
    input  logic            b_load_n,
    input  logic            rnd_in,
    input  logic            fmt_full,
    input  logic            res_load_n,
    input  logic            pass_thru,
    input  logic            hi_sel,
    input  logic            main_oe,
    input  logic            low_oe,
    output logic [OP_W-1:0] main_out,
    output logic            main_vld,
    output logic [OP_W-1:0] low_out,
    output logic            low_vld
);
    localparam int PROD_W = 2 * OP_W;
    localparam int N_OPND = 2;

    logic [N_OPND-1:0][OP_W-1:0] opnd_d;
    logic [N_OPND-1:0][OP_W-1:0] opnd_q;
    logic [N_OPND-1:0]           tc_d;
    logic [N_OPND-1:0]           tc_q;
    logic [N_OPND-1:0]           ld_n;

    logic [OP_W-1:0]   a_q;
    logic [OP_W-1:0]   b_q;
    logic              rnd_q;
    logic [PROD_W-1:0] prod;
    logic [OP_W-1:0]   fmt_hi;
    logic [OP_W-1:0]   fmt_lo;
    logic [OP_W-1:0]   res_hi;
    logic [OP_W-1:0]   res_lo;

    assign opnd_d = {b_in, a_in};
    assign tc_d   = {b_tc, a_tc};
    assign ld_n   = {b_load_n, a_load_n};

    for (genvar i = 0; i < N_OPND; i++) begin : g_opnd
        opnd_reg #(.W(OP_W)) i_opnd (
            .clk    (clk),
            .rst    (rst),
            .load_n (ld_n[i]),
            .d      (opnd_d[i]),
            .tc_d   (tc_d[i]),
            .q      (opnd_q[i]),
            .tc_q   (tc_q[i])
        );
    end

    assign a_q = opnd_q[0];
    assign b_q = opnd_q[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            rnd_q <= 1'b0;
        end else if (!a_load_n || !b_load_n) begin
            rnd_q <= rnd_in;
        end
    end

    round_mult #(.W(OP_W)) i_mult (
        .a    (a_q),
        .a_tc (tc_q[0]),
        .b    (b_q),
        .b_tc (tc_q[1]),
        .rnd  (rnd_q),
        .prod (prod)
    );

    fmt_adj #(.W(OP_W)) i_fmt (
        .prod (prod),
        .full (fmt_full),
        .hi   (fmt_hi),
        .lo   (fmt_lo)
    );

    res_out #(.W(OP_W)) i_res (
        .clk      (clk),
        .rst      (rst),
        .load_n   (res_load_n),
        .pass     (pass_thru),
        .hi_d     (fmt_hi),
        .lo_d     (fmt_lo),
        .sel      (hi_sel),
        .main_oe  (main_oe),
        .low_oe   (low_oe),
        .hi_q     (res_hi),
        .lo_q     (res_lo),
        .main_out (main_out),
        .main_vld (main_vld),
        .low_out  (low_out),
        .low_vld  (low_vld)
    );
endmodule

// File: rtl/cfgsign_mul_chk.sv
module cfgsign_mul_chk #(
    parameter int OP_W = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            a_load_n,
    input logic            b_load_n,
    input logic            res_load_n,
    input logic            hi_sel,
    input logic            main_oe,
    input logic            low_oe,
    input logic [OP_W-1:0] a_q,
    input logic [OP_W-1:0] b_q,
    input logic            rnd_q,
    input logic [OP_W-1:0] fmt_hi,
    input logic [OP_W-1:0] fmt_lo,
    input logic [OP_W-1:0] res_hi,
    input logic [OP_W-1:0] res_lo,
    input logic [OP_W-1:0] main_out,
    input logic            main_vld,
    input logic [OP_W-1:0] low_out,
    input logic            low_vld
);
    assert_a_hold_R1: assert property (@(posedge clk) disable iff (rst)
        a_load_n |=> $stable(a_q));

    assert_b_hold_R2: assert property (@(posedge clk) disable iff (rst)
        b_load_n |=> $stable(b_q));

    assert_rnd_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (a_load_n && b_load_n) |=> $stable(rnd_q));

    assert_res_load_R8: assert property (@(posedge clk) disable iff (rst)
        !res_load_n |=> (res_hi == $past(fmt_hi) && res_lo == $past(fmt_lo)));

    assert_res_hold_R8: assert property (@(posedge clk) disable iff (rst)
        res_load_n |=> ($stable(res_hi) && $stable(res_lo)));

    assert_mux_low_R10: assert property (@(posedge clk) disable iff (rst)
        (main_oe && low_oe && hi_sel) |-> (main_out == low_out));

    assert_main_off_R11: assert property (@(posedge clk) disable iff (rst)
        !main_oe |-> (main_out == '0 && !main_vld));

    assert_low_off_R11: assert property (@(posedge clk) disable iff (rst)
        !low_oe |-> (low_out == '0 && !low_vld));
endmodule

bind cfgsign_mul cfgsign_mul_chk #(.OP_W(OP_W)) i_cfgsign_mul_chk (.*);

// File: tb/test_cfgsign_mul.sv
module test_cfgsign_mul;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] a_in, b_in;
    logic        a_tc, b_tc, a_load_n, b_load_n, rnd_in, fmt_full;
    logic        res_load_n, pass_thru, hi_sel, main_oe, low_oe;
    logic [15:0] main_out, low_out;
    logic        main_vld, low_vld;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    logic [15:0] m_a, m_b, m_hi, m_lo;
    logic        m_atc, m_btc, m_rnd;

    always #10 clk = ~clk;

    cfgsign_mul i_cfgsign_mul (
        .clk(clk), .rst(rst), .a_in(a_in), .a_tc(a_tc), .a_load_n(a_load_n),
        .b_in(b_in), .b_tc(b_tc), .b_load_n(b_load_n), .rnd_in(rnd_in),
        .fmt_full(fmt_full), .res_load_n(res_load_n), .pass_thru(pass_thru),
        .hi_sel(hi_sel), .main_oe(main_oe), .low_oe(low_oe),
        .main_out(main_out), .main_vld(main_vld), .low_out(low_out), .low_vld(low_vld)
    );

    function automatic logic [31:0] ref_prod(logic [15:0] a, logic at, logic [15:0] b,
                                             logic bt, logic r);
        logic signed [16:0] ea, eb;
        logic signed [33:0] p;
        ea = at ? $signed({a[15], a}) : $signed({1'b0, a});
        eb = bt ? $signed({b[15], b}) : $signed({1'b0, b});
        p  = ea * eb;
        return p[31:0] + (r ? 32'h0000_8000 : 32'h0);
    endfunction

    function automatic logic [31:0] ref_fmt(logic [31:0] p, logic full);
        return full ? p : {p[30:15], p[31], p[14:0]};
    endfunction

    task automatic check_val(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_outs(string tag);
        logic [31:0] v;
        logic [15:0] e_main, e_low;
        if (pass_thru && !res_load_n)
            v = ref_fmt(ref_prod(m_a, m_atc, m_b, m_btc, m_rnd), fmt_full);
        else
            v = {m_hi, m_lo};
        e_main = main_oe ? (hi_sel ? v[15:0] : v[31:16]) : 16'h0;
        e_low  = low_oe ? v[15:0] : 16'h0;
        check_val({tag, " main_out"}, 32'(main_out), 32'(e_main));
        check_val({tag, " low_out"},  32'(low_out),  32'(e_low));
        check_val({tag, " vld R11"},  {30'h0, main_vld, low_vld}, {30'h0, main_oe, low_oe});
    endtask

    task automatic step(string tag);
        logic [31:0] f;
        @(posedge clk);
        if (rst) begin
            m_a = '0; m_b = '0; m_atc = 0; m_btc = 0; m_rnd = 0; m_hi = '0; m_lo = '0;
        end else begin
            f = ref_fmt(ref_prod(m_a, m_atc, m_b, m_btc, m_rnd), fmt_full);
            if (!res_load_n) {m_hi, m_lo} = f;
            if (!a_load_n) begin m_a = a_in; m_atc = a_tc; end
            if (!b_load_n) begin m_b = b_in; m_btc = b_tc; end
            if (!a_load_n || !b_load_n) m_rnd = rnd_in;
        end
        @(negedge clk);
        if (!rst) check_outs(tag);
    endtask

    task automatic load_ops(logic [15:0] a, logic at, logic [15:0] b, logic bt, logic r);
        a_in = a; a_tc = at; b_in = b; b_tc = bt; rnd_in = r;
        a_load_n = 0; b_load_n = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1; a_in = 16'h1234; b_in = 16'h5678; a_tc = 1; b_tc = 1; rnd_in = 1;
        a_load_n = 0; b_load_n = 0; fmt_full = 1; res_load_n = 0; pass_thru = 0;
        hi_sel = 0; main_oe = 1; low_oe = 1;
        step("R12"); step("R12");
        rst = 0; a_load_n = 1; b_load_n = 1;
        step("R12 reset");
        check_val("R12 main after reset", 32'(main_out), 32'h0);
        check_val("R12 low after reset", 32'(low_out), 32'h0);

        // signed * signed: -1 * 2
        load_ops(16'hFFFF, 1, 16'h0002, 1, 0);
        step("R3"); step("R3");
        check_val("R3 signed upper", 32'(main_out), 32'hFFFF);
        check_val("R3 signed lower", 32'(low_out), 32'hFFFE);
        // unsigned * unsigned
        load_ops(16'hFFFF, 0, 16'h0002, 0, 0);
        step("R3"); step("R3");
        check_val("R3 unsigned upper", 32'(main_out), 32'h0001);
        // mixed: -1 * 65535
        load_ops(16'hFFFF, 1, 16'hFFFF, 0, 0);
        step("R3"); step("R3");
        check_val("R3 mixed", {16'(main_out), 16'(low_out)}, 32'hFFFF_0001);
        hi_sel = 1;
        step("R10");
        check_val("R10 lower on main", 32'(main_out), 32'h0001);
        hi_sel = 0;

        // rounding carry out of bit 15
        load_ops(16'h0001, 0, 16'h8000, 0, 1);
        step("R5"); step("R5");
        check_val("R5 round carry", {16'(main_out), 16'(low_out)}, 32'h0001_0000);

        // shifted layout: most negative squared, with rounding
        fmt_full = 0;
        load_ops(16'h8000, 1, 16'h8000, 1, 1);
        step("R6"); step("R6");
        check_val("R6 shifted square", {16'(main_out), 16'(low_out)}, 32'h8001_0000);
        // product bit15 set, sign 0: sign copy must replace bit 15
        load_ops(16'h0100, 0, 16'h0080, 0, 0);
        step("R6"); step("R6");
        check_val("R6 sign copy", {16'(main_out), 16'(low_out)}, 32'h0001_0000);
        load_ops(16'hFFFD, 1, 16'h0005, 1, 0);
        step("R6"); step("R6");
        check_val("R6 negative", {16'(main_out), 16'(low_out)}, 32'hFFFF_FFF1);
        fmt_full = 1;
        step("R7");
        check_val("R7 full negative", {16'(main_out), 16'(low_out)}, 32'hFFFF_FFF1);

        // operand A hold
        load_ops(16'h0003, 0, 16'h0004, 0, 0);
        step("R1"); step("R1");
        a_load_n = 1; a_in = 16'h0100;
        step("R1 hold"); step("R1 hold");
        check_val("R1 A held", 32'(low_out), 32'h000C);
        // operand B hold
        a_load_n = 0; a_in = 16'h0005; b_load_n = 1; b_in = 16'h0100;
        step("R2 hold"); step("R2 hold");
        check_val("R2 B held", 32'(low_out), 32'h0014);
        // rounding request hold
        a_load_n = 1; b_load_n = 1; rnd_in = 1;
        step("R4 hold"); step("R4 hold");
        check_val("R4 rnd held", 32'(low_out), 32'h0014);
        a_load_n = 0;
        step("R4 load"); step("R4 load");
        check_val("R4 rnd loaded", 32'(low_out), 32'h8014);

        // result register hold
        res_load_n = 1;
        load_ops(16'h0007, 0, 16'h0007, 0, 0);
        step("R8 hold"); step("R8 hold");
        check_val("R8 result held", 32'(low_out), 32'h8014);
        res_load_n = 0;
        step("R8 load");
        check_val("R8 result loaded", 32'(low_out), 32'h0031);

        // feed-through: visible one edge after operand capture
        pass_thru = 1;
        load_ops(16'h0009, 0, 16'h0009, 0, 0);
        step("R9");
        check_val("R9 passthrough", 32'(low_out), 32'h0051);
        pass_thru = 0;

        // output enables
        main_oe = 0; low_oe = 0;
        step("R11");
        check_val("R11 main off", {31'h0, main_vld}, 32'h0);
        check_val("R11 low off", 32'(low_out), 32'h0);
        main_oe = 1; low_oe = 1;

        // seeded random
        void'($urandom(32'd20240611));
        for (int i = 0; i < 800; i++) begin
            a_in = 16'($urandom); b_in = 16'($urandom);
            a_tc = 1'($urandom); b_tc = 1'($urandom); rnd_in = 1'($urandom);
            a_load_n = ($urandom % 4) == 0; b_load_n = ($urandom % 4) == 0;
            fmt_full = 1'($urandom); res_load_n = ($urandom % 4) == 0;
            pass_thru = ($urandom % 3) == 0; hi_sel = 1'($urandom);
            main_oe = ($urandom % 4) != 0; low_oe = ($urandom % 4) != 0;
            step("R7 R10 random");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule